// File: doc/BRIEF.md
# Programmable Asynchronous Memory Bus Controller

This block runs single accesses to one external asynchronous memory bank on behalf of an internal requester. A request carries an address, byte enables, a read/write flag and write data. The block then steps through four phases: setup, access, hold and bus turnaround. Each phase lasts a number of clock cycles taken from its own timing input. From these phases it drives the bank's active-low select, byte-enable, output-enable, read-strobe and write-strobe pins.

Read data is captured at the clock edge that closes the access phase. It is returned with a one-cycle done pulse when the hold phase ends. A new request can be taken in the last turnaround cycle. Back-to-back accesses to the bank therefore run with only the programmed gap between them, whatever mix of reads and writes they are.

Top module: `async_mem_ctrl`

## Requirements
- R1: While reset is active, and when no access is in progress, mem_cs_n, mem_oe_n, mem_rd_n and mem_wr_n are 1, mem_be_n is all ones, mem_wdata_oe is 0 and rsp_done is 0.
- R2: Setup starts in the cycle after a request is accepted and lasts max(cfg_setup,1) cycles. During setup, mem_cs_n is 0, mem_addr equals the request address and mem_be_n equals the inverted request byte enables. mem_oe_n is 0 for a read, and mem_rd_n and mem_wr_n stay 1.
- R3: For a read, mem_rd_n is 0 only during the access phase. The access phase directly follows setup and lasts max(cfg_access,1) cycles.
- R4: For a read, rsp_rdata equals the value on mem_rdata at the rising edge that ends the last access cycle. A later change of mem_rdata does not alter it.
- R5: The hold phase follows access and lasts max(cfg_hold,1) cycles. During hold, select, address, byte enables and (for a read) mem_oe_n keep their setup values while both strobes are 1. Select, byte enables and output enable are released when hold ends.
- R6: After hold, a gap of max(cfg_turn,1) cycles follows with all strobes and selects deasserted, before the next setup. The gap is the same for read-read, read-write, write-read and write-write orderings.
- R7: For a write, mem_wr_n is 0 exactly during the access phase and mem_oe_n stays 1. mem_wdata_oe is 1 with mem_wdata equal to the request data from the first setup cycle through the last hold cycle.
- R8: A timing input of zero gives a phase of exactly one cycle.
- R9: rsp_done is 1 for exactly one cycle, the first cycle after the hold phase ends, for both reads and writes.
- R10: req_ready is 1 when idle and in the last turnaround cycle, and 0 otherwise. A request with req_valid and req_ready both 1 at a rising edge starts setup in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_setup | input | CNT_W | Setup length in cycles (0 means 1) |
| cfg_access | input | CNT_W | Access length in cycles (0 means 1) |
| cfg_hold | input | CNT_W | Hold length in cycles (0 means 1) |
| cfg_turn | input | CNT_W | Turnaround gap in cycles (0 means 1) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_be | input | BE_W | Byte enables, active high |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| mem_cs_n | output | 1 | Bank select, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_be_n | output | BE_W | Byte enables, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_wdata | output | DATA_W | Write data to the bus |
| mem_wdata_oe | output | 1 | Write data drive enable |
| mem_rdata | input | DATA_W | Read data from the bus |

## Verification
The bench first uses the 1/3/2/1 timing with two reads in a row, which checks the basic phase order and the point of read capture. It then mixes the orderings read-write, write-read and write-write, to show that the gap and strobe choice do not depend on the previous access. An all-zero timing set separates "zero means one cycle" from "zero skips the phase". Uneven long settings catch any mix-up between the phase counters. mem_rdata changes every cycle, so capture one edge early or late gives a wrong value. Requests are issued both from idle and while the previous access is still running, so that both acceptance points are covered.

// File: rtl/async_mem_ctrl.sv
module async_mem_ctrl #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_access,
  input  logic [CNT_W-1:0]  cfg_hold,
  input  logic [CNT_W-1:0]  cfg_turn,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_cs_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BE_W-1:0]   mem_be_n,
  output logic              mem_oe_n,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wdata_oe,
  input  logic [DATA_W-1:0] mem_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_ACCESS, S_HOLD, S_TURN} phase_t;

  phase_t             phase;
  logic [CNT_W-1:0]   cnt;
  logic               wr_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [BE_W-1:0]    be_q;
  logic [DATA_W-1:0]  wdata_q;

  function automatic logic [CNT_W-1:0] remain(input logic [CNT_W-1:0] len);
    return (len == '0) ? '0 : len - 1'b1;
  endfunction

  wire last   = (cnt == '0);
  wire active = (phase == S_SETUP) || (phase == S_ACCESS) || (phase == S_HOLD);
  wire accept = req_valid && req_ready;

  assign req_ready    = (phase == S_IDLE) || ((phase == S_TURN) && last);
  assign mem_cs_n     = !active;
  assign mem_addr     = addr_q;
  assign mem_be_n     = active ? ~be_q : '1;
  assign mem_oe_n     = !(active && !wr_q);
  assign mem_rd_n     = !((phase == S_ACCESS) && !wr_q);
  assign mem_wr_n     = !((phase == S_ACCESS) && wr_q);
  assign mem_wdata    = wdata_q;
  assign mem_wdata_oe = active && wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= S_IDLE;
      cnt       <= '0;
      wr_q      <= 1'b0;
      addr_q    <= '0;
      be_q      <= '0;
      wdata_q   <= '0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      case (phase)
        S_IDLE, S_TURN: begin
          if (accept) begin
            phase   <= S_SETUP;
            cnt     <= remain(cfg_setup);
            wr_q    <= req_write;
            addr_q  <= req_addr;
            be_q    <= req_be;
            wdata_q <= req_wdata;
          end else if (phase == S_TURN) begin
            if (last) phase <= S_IDLE;
            else      cnt   <= cnt - 1'b1;
          end
        end
        S_SETUP: begin
          if (last) begin
            phase <= S_ACCESS;
            cnt   <= remain(cfg_access);
          end else cnt <= cnt - 1'b1;
        end
        S_ACCESS: begin
          if (last) begin
            phase <= S_HOLD;
            cnt   <= remain(cfg_hold);
            if (!wr_q) rsp_rdata <= mem_rdata;
          end else cnt <= cnt - 1'b1;
        end
        S_HOLD: begin
          if (last) begin
            phase    <= S_TURN;
            cnt      <= remain(cfg_turn);
            rsp_done <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        default: phase <= S_IDLE;
      endcase
    end
  end

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && !mem_wr_n));

  p_rd_in_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_n |-> !mem_cs_n && !mem_oe_n);

  p_wr_no_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> mem_oe_n && mem_wdata_oe);

  p_addr_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr) && $stable(mem_be_n));

  p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs_n) |-> mem_rd_n && mem_wr_n && mem_oe_n && !req_ready || cfg_turn <= 1);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_done_after_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_done) |-> mem_cs_n && !$past(mem_cs_n));

endmodule

// File: tb/async_mem_ctrl_bench.sv
`timescale 1ns/1ps
module async_mem_ctrl_bench;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 4;
  localparam int BE_W   = DATA_W / 8;

  logic clk = 0;
  logic rst_n = 0;
  logic [CNT_W-1:0] cfg_setup = 1, cfg_access = 3, cfg_hold = 2, cfg_turn = 1;
  logic req_valid = 0, req_write = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [BE_W-1:0] req_be = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rsp_done, mem_cs_n, mem_oe_n, mem_rd_n, mem_wr_n, mem_wdata_oe;
  logic [DATA_W-1:0] rsp_rdata, mem_wdata;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic [ADDR_W-1:0] mem_addr;
  logic [BE_W-1:0] mem_be_n;

  always #2.5 clk = ~clk;

  async_mem_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_async_mem_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_setup(cfg_setup), .cfg_access(cfg_access), .cfg_hold(cfg_hold), .cfg_turn(cfg_turn),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_cs_n(mem_cs_n), .mem_addr(mem_addr), .mem_be_n(mem_be_n), .mem_oe_n(mem_oe_n),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_wdata(mem_wdata),
    .mem_wdata_oe(mem_wdata_oe), .mem_rdata(mem_rdata));

  typedef struct {
    bit cs_n, oe_n, rd_n, wr_n, wd_en, done, cap, chk;
    logic [ADDR_W-1:0] addr;
    logic [BE_W-1:0] be_n;
    logic [DATA_W-1:0] wdata;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [DATA_W-1:0] cap_val = '0;
  string extra = "";

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic int eff(input logic [CNT_W-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  function automatic exp_t idle_e(string tag);
    exp_t e;
    e.cs_n = 1; e.oe_n = 1; e.rd_n = 1; e.wr_n = 1; e.wd_en = 0; e.done = 0;
    e.cap = 0; e.chk = 0; e.addr = '0; e.be_n = '1; e.wdata = '0; e.tag = tag;
    return e;
  endfunction

  task automatic push_req(bit w, logic [ADDR_W-1:0] a, logic [BE_W-1:0] be, logic [DATA_W-1:0] d);
    exp_t b;
    int ns = eff(cfg_setup), na = eff(cfg_access), nh = eff(cfg_hold), nt = eff(cfg_turn);
    b = idle_e("");
    b.cs_n = 0; b.addr = a; b.be_n = ~be; b.oe_n = w; b.wd_en = w; b.wdata = d;
    for (int i = 0; i < ns; i++) begin exp_t e = b; e.tag = {"R2", extra}; q.push_back(e); end
    for (int i = 0; i < na; i++) begin
      exp_t e = b;
      e.tag = w ? {"R7", extra} : {"R3", extra};
      if (w) e.wr_n = 0; else e.rd_n = 0;
      e.cap = !w && (i == na - 1);
      q.push_back(e);
    end
    for (int i = 0; i < nh; i++) begin exp_t e = b; e.tag = {"R5", extra}; q.push_back(e); end
    for (int i = 0; i < nt; i++) begin
      exp_t e = idle_e({"R6", extra});
      if (i == 0) begin e.done = 1; e.chk = !w; e.tag = {"R9", extra}; end
      q.push_back(e);
    end
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) e = q.pop_front(); else e = idle_e("R1");
    check(mem_cs_n == e.cs_n, e.tag, "cs_n", 64'(mem_cs_n), 64'(e.cs_n));
    check(mem_oe_n == e.oe_n, e.tag, "oe_n", 64'(mem_oe_n), 64'(e.oe_n));
    check(mem_rd_n == e.rd_n, e.tag, "rd_n", 64'(mem_rd_n), 64'(e.rd_n));
    check(mem_wr_n == e.wr_n, e.tag, "wr_n", 64'(mem_wr_n), 64'(e.wr_n));
    check(mem_be_n == e.be_n, e.tag, "be_n", 64'(mem_be_n), 64'(e.be_n));
    check(mem_wdata_oe == e.wd_en, {"R7 ", e.tag}, "wdata_oe", 64'(mem_wdata_oe), 64'(e.wd_en));
    check(rsp_done == e.done, {"R9 ", e.tag}, "done", 64'(rsp_done), 64'(e.done));
    if (!e.cs_n) check(mem_addr == e.addr, {"R2 ", e.tag}, "addr", 64'(mem_addr), 64'(e.addr));
    if (e.wd_en) check(mem_wdata == e.wdata, {"R7 ", e.tag}, "wdata", 64'(mem_wdata), 64'(e.wdata));
    if (e.cap) cap_val = mem_rdata;
    if (e.chk) check(rsp_rdata == cap_val, {"R4 ", e.tag}, "rdata", 64'(rsp_rdata), 64'(cap_val));
    check(req_ready == (q.size() == 0), "R10", "ready", 64'(req_ready), 64'(q.size() == 0));
    if (rst_n && req_valid && req_ready) push_req(req_write, req_addr, req_be, req_wdata);
  end

  always @(posedge clk) begin
    cyc++;
    #1 mem_rdata = {cyc[15:0] ^ 16'h5a00, mem_addr[15:0]};
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic do_req(bit w, logic [ADDR_W-1:0] a, logic [BE_W-1:0] be, logic [DATA_W-1:0] d);
    bit r;
    req_valid = 1; req_write = w; req_addr = a; req_be = be; req_wdata = d;
    forever begin
      @(negedge clk); r = req_ready;
      @(posedge clk); #1;
      if (r) break;
    end
    req_valid = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    // reference timing: read then read (R3, R4, R6)
    do_req(0, 20'h00100, 4'hF, 32'h0);
    do_req(0, 20'h00104, 4'h3, 32'h0);
    // orderings R6, R7
    do_req(1, 20'h00200, 4'hC, 32'hCAFE_0001);
    do_req(0, 20'h00204, 4'h1, 32'h0);
    do_req(1, 20'h00208, 4'hF, 32'hBEEF_0002);
    do_req(1, 20'h0020C, 4'h6, 32'h1234_5678);
    wait_idle();
    // zero durations R8
    extra = " R8";
    cfg_setup = 0; cfg_access = 0; cfg_hold = 0; cfg_turn = 0;
    do_req(0, 20'h00300, 4'hF, 32'h0);
    do_req(1, 20'h00304, 4'h9, 32'hA5A5_5A5A);
    do_req(0, 20'h00308, 4'h2, 32'h0);
    wait_idle();
    extra = "";
    cfg_setup = 3; cfg_access = 2; cfg_hold = 4; cfg_turn = 3;
    do_req(0, 20'hFFFFF, 4'hF, 32'h0);
    do_req(1, 20'h00400, 4'h8, 32'h0F0F_F0F0);
    do_req(0, 20'h00404, 4'hF, 32'h0);
    wait_idle();
    cfg_setup = 2; cfg_access = 1; cfg_hold = 1; cfg_turn = 5;
    do_req(1, 20'h00500, 4'hF, 32'hFFFF_FFFF);
    do_req(0, 20'h00504, 4'h4, 32'h0);
    wait_idle();
    cfg_setup = 15; cfg_access = 7; cfg_hold = 1; cfg_turn = 2;
    do_req(0, 20'h00600, 4'hF, 32'h0);
    do_req(0, 20'h00604, 4'hF, 32'h0);
    wait_idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule